// File: doc/BRIEF.md
# Single-Step Non-Restoring Divider

This block divides a 32-bit dividend by a 16-bit divisor one quotient bit at a time. It is built around a working register that holds the partial remainder, a divisor register, and three one-bit flags: Q, M and T. The flags carry state from one step to the next. Two commands drive the datapath. The prepare command clears the three flags. The step command produces one quotient bit per clock. Each step is a whole operation on its own, so any pause between steps costs nothing in correctness, and other work can be taken between any two of them.

A sequencer wraps the datapath. When `startI` is asserted it loads the operands, issues the prepare command, runs sixteen steps, and then performs one rotate through T. The rotate brings in the final quotient bit. The quotient is read from the low half of the working register, zero-extended to 32 bits. The upper half is left over from the arithmetic and holds no usable result.

The caller must make sure the divisor is nonzero and that the upper half of the dividend is smaller than the divisor. When the sequencer is idle, the same load, prepare and step commands can also be issued one at a time from the ports.

Top module: `divstep_top`

## Requirements
- R1: While `rstN` is low, `busyO` and `doneO` are 0, `workO` is 0, and `tFlagO` and `qFlagO` are 0.
- R2: A load, from `loadI` or `startI` while idle, copies `dividendI` into the working register. It also places `divisorI` in bits 31:16 of the divisor register, with zeros in bits 15:0.
- R3: The prepare command clears Q, M and T in the cycle after it is accepted.
- R4: A step works from the working register W and the divisor register D, as follows:
  - It forms S = {W[30:0], T}.
  - It computes S − D when Q equals M, and S + D otherwise. This result is 32 bits, plus a carry or borrow bit c.
  - It writes the result into W.
  - It sets Q to the old W[31] XOR c XOR M.
  - It sets T to NOT(Q XOR M), using the new Q.
- R5: Once `startI` is accepted while idle, `busyO` is high for 19 cycles:
  - one prepare cycle;
  - sixteen step cycles;
  - one rotate cycle;
  - one finish cycle, in which `doneO` is high for exactly that cycle.
- R6: In the cycle where `doneO` is high, `quotientO` equals floor(dividend / divisor), provided the preconditions hold. Bits 31:16 of `quotientO` are 0.
- R7: While `busyO` is high, `startI`, `loadI`, `initI` and `stepI` have no effect.
- R8: When idle and several commands are asserted together, only one is taken. The order of precedence is start, then load, then prepare, then step.
- R9: The rotate shifts W left by one bit with the old T entering bit 0. The old W[31] becomes the new T.
- R10: When idle with no command asserted, `workO`, `tFlagO` and `qFlagO` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startI | input | 1 | Load operands and run a complete divide |
| loadI | input | 1 | Load operands only |
| initI | input | 1 | Manual prepare command |
| stepI | input | 1 | Manual one-bit step |
| dividendI | input | 32 | Dividend |
| divisorI | input | 16 | Divisor |
| busyO | output | 1 | Sequenced divide in progress |
| doneO | output | 1 | One-cycle pulse when the quotient is ready |
| quotientO | output | 32 | Low half of the working register, zero-extended |
| workO | output | 32 | Working register (partial remainder) |
| tFlagO | output | 1 | T flag |
| qFlagO | output | 1 | Q flag |

## Verification
Several operand pairs are run through full divides:
- a zero dividend;
- a divisor of one;
- the largest legal dividend for a given divisor;
- operands whose quotient bits alternate between the add path and the subtract path.

Comparing each cycle against a bit-level model pinpoints a wrong add/subtract choice or a wrong flag update in the exact step where it happens. Comparing the final quotient against integer division catches errors in the shift-in order or in the last rotate.

Manual command sequences with flags left nonzero show that prepare really clears them. Commands issued together while idle show the order of precedence. Commands issued during a run show that they are ignored.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

  // Strobes the sequencer hands to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;
    logic init;
    logic step;
    logic rot;
  } stepCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_STEP,
    ST_ROT,
    ST_FIN
  } seqState_t;

endpackage

// File: rtl/divstep_dp.sv
module divstep_dp
  import divstep_pkg::*;
#(
  parameter int QUO_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stepCmd_t             cmd,
  input  logic [2*QUO_W-1:0]   dividendI,
  input  logic [QUO_W-1:0]     divisorI,
  output logic [2*QUO_W-1:0]   workO,
  output logic                 tFlagO,
  output logic                 qFlagO
);

  localparam int DATA_W = 2 * QUO_W;

  logic [DATA_W-1:0] workQ;
  logic [DATA_W-1:0] dvsQ;
  logic              qQ;
  logic              mQ;
  logic              tQ;

  // One non-restoring step, evaluated combinationally.
  logic [DATA_W-1:0] shifted;
  logic [DATA_W:0]   sumX;
  logic              doSub;
  logic              carry;
  logic              stepQ;
  logic              stepT;

  always_comb begin
    shifted = {workQ[DATA_W-2:0], tQ};
    doSub   = (qQ == mQ);
    if (doSub) begin
      sumX = {1'b0, shifted} - {1'b0, dvsQ};
    end else begin
      sumX = {1'b0, shifted} + {1'b0, dvsQ};
    end
    carry = sumX[DATA_W];
    stepQ = workQ[DATA_W-1] ^ carry ^ mQ;
    stepT = ~(stepQ ^ mQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workQ <= '0;
      dvsQ  <= '0;
      qQ    <= 1'b0;
      mQ    <= 1'b0;
      tQ    <= 1'b0;
    end else if (cmd.load) begin
      workQ <= dividendI;
      dvsQ  <= {divisorI, {QUO_W{1'b0}}};
    end else if (cmd.init) begin
      qQ <= 1'b0;
      mQ <= 1'b0;
      tQ <= 1'b0;
    end else if (cmd.step) begin
      workQ <= sumX[DATA_W-1:0];
      qQ    <= stepQ;
      tQ    <= stepT;
    end else if (cmd.rot) begin
      workQ <= {workQ[DATA_W-2:0], tQ};
      tQ    <= workQ[DATA_W-1];
    end
  end

  assign workO  = workQ;
  assign tFlagO = tQ;
  assign qFlagO = qQ;

endmodule

// File: rtl/divstep_ctrl.sv
module divstep_ctrl
  import divstep_pkg::*;
#(
  parameter int QUO_W = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startI,
  input  logic     loadI,
  input  logic     initI,
  input  logic     stepI,
  output stepCmd_t cmd,
  output logic     busyO,
  output logic     doneO
);

  localparam int CNT_W = $clog2(QUO_W + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(QUO_W - 1);

  seqState_t         stateQ;
  seqState_t         stateD;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  cntD;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    cmd    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startI) begin
          cmd.load = 1'b1;
          stateD   = ST_INIT;
        end else if (loadI) begin
          cmd.load = 1'b1;
        end else if (initI) begin
          cmd.init = 1'b1;
        end else if (stepI) begin
          cmd.step = 1'b1;
        end
      end
      ST_INIT: begin
        cmd.init = 1'b1;
        cntD     = '0;
        stateD   = ST_STEP;
      end
      ST_STEP: begin
        cmd.step = 1'b1;
        cntD     = cntQ + 1'b1;
        if (cntQ == LAST_STEP) begin
          stateD = ST_ROT;
        end
      end
      ST_ROT: begin
        cmd.rot = 1'b1;
        stateD  = ST_FIN;
      end
      ST_FIN: begin
        stateD = ST_IDLE;
      end
      default: begin
        stateD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign busyO = (stateQ != ST_IDLE);
  assign doneO = (stateQ == ST_FIN);

endmodule

// File: rtl/divstep_top.sv
module divstep_top
  import divstep_pkg::*;
#(
  parameter int QUO_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startI,
  input  logic                loadI,
  input  logic                initI,
  input  logic                stepI,
  input  logic [2*QUO_W-1:0]  dividendI,
  input  logic [QUO_W-1:0]    divisorI,
  output logic                busyO,
  output logic                doneO,
  output logic [2*QUO_W-1:0]  quotientO,
  output logic [2*QUO_W-1:0]  workO,
  output logic                tFlagO,
  output logic                qFlagO
);

  stepCmd_t cmd;

  divstep_ctrl #(.QUO_W(QUO_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .startI (startI),
    .loadI  (loadI),
    .initI  (initI),
    .stepI  (stepI),
    .cmd    (cmd),
    .busyO  (busyO),
    .doneO  (doneO)
  );

  divstep_dp #(.QUO_W(QUO_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .dividendI (dividendI),
    .divisorI  (divisorI),
    .workO     (workO),
    .tFlagO    (tFlagO),
    .qFlagO    (qFlagO)
  );

  // Upper half is leftover remainder-like data; only the low half is the result.
  assign quotientO = {{QUO_W{1'b0}}, workO[QUO_W-1:0]};

endmodule

// File: rtl/divstep_chk.sv
module divstep_chk #(
  parameter int QUO_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               startI,
  input logic               loadI,
  input logic               initI,
  input logic               stepI,
  input logic [2*QUO_W-1:0] dividendI,
  input logic               busyO,
  input logic               doneO,
  input logic [2*QUO_W-1:0] workO,
  input logic               tFlagO,
  input logic               qFlagO
);

  localparam int RUN_LEN = QUO_W + 3;
  localparam int RC_W    = $clog2(RUN_LEN + 2);

  logic [RC_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (startI && !busyO) begin
      runCnt <= RC_W'(1);
    end else if (busyO) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // R5
  done_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> (runCnt == RC_W'(RUN_LEN)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startI && !busyO) |=> (busyO && !doneO));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyO && !doneO) |=> busyO);

  // R3
  init_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyO && initI && !startI && !loadI) |=> (!tFlagO && !qFlagO));

  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyO && loadI && !startI) |=> (workO == $past(dividendI)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyO && !startI && !loadI && !initI && !stepI)
      |=> ($stable(workO) && $stable(tFlagO) && $stable(qFlagO)));

endmodule

bind divstep_top divstep_chk #(.QUO_W(QUO_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .startI    (startI),
  .loadI     (loadI),
  .initI     (initI),
  .stepI     (stepI),
  .dividendI (dividendI),
  .busyO     (busyO),
  .doneO     (doneO),
  .workO     (workO),
  .tFlagO    (tFlagO),
  .qFlagO    (qFlagO)
);

// File: tb/divstep_tb.sv
module divstep_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic        loadI = 1'b0;
  logic        initI = 1'b0;
  logic        stepI = 1'b0;
  logic [31:0] dividendI = '0;
  logic [15:0] divisorI = '0;
  logic        busyO;
  logic        doneO;
  logic [31:0] quotientO;
  logic [31:0] workO;
  logic        tFlagO;
  logic        qFlagO;

  int testCnt = 0;
  int failCnt = 0;
  int cycCnt = 0;
  bit chkEn = 1'b0;

  always #4 clk = ~clk;

  divstep_top dut_i (
    .clk(clk), .rstN(rstN), .startI(startI), .loadI(loadI), .initI(initI),
    .stepI(stepI), .dividendI(dividendI), .divisorI(divisorI), .busyO(busyO),
    .doneO(doneO), .quotientO(quotientO), .workO(workO), .tFlagO(tFlagO),
    .qFlagO(qFlagO)
  );

  // Behavioural reference model
  logic [31:0] mWork = '0;
  logic [31:0] mDvs = '0;
  bit mQ = 0, mM = 0, mT = 0;
  int mPhase = 0;   // 0 idle, 1 prepare, 2 stepping, 3 rotate, 4 finish
  int mSteps = 0;
  string mTag = "R1";

  task automatic modelStep();
    longint unsigned s, d, r;
    bit c, oldMsb;
    oldMsb = mWork[31];
    s = {32'h0, mWork[30:0], mT};
    d = {32'h0, mDvs};
    if (mQ == mM) r = s - d;
    else r = s + d;
    c = r[32];
    mWork = r[31:0];
    mQ = oldMsb ^ c ^ mM;
    mT = !(mQ ^ mM);
  endtask

  always @(posedge clk) begin
    cycCnt++;
    if (!rstN) begin
      mWork = '0; mDvs = '0; mQ = 0; mM = 0; mT = 0; mPhase = 0; mSteps = 0; mTag = "R1";
    end else begin
      case (mPhase)
        0: begin
          if ((startI + loadI + initI + stepI) > 1) mTag = "R8";
          else if (startI) mTag = "R5";
          else if (loadI) mTag = "R2";
          else if (initI) mTag = "R3";
          else if (stepI) mTag = "R4";
          else mTag = "R10";
          if (startI || loadI) begin
            mWork = dividendI;
            mDvs = {divisorI, 16'h0};
            if (startI) mPhase = 1;
          end else if (initI) begin
            mQ = 0; mM = 0; mT = 0;
          end else if (stepI) begin
            modelStep();
          end
        end
        1: begin mQ = 0; mM = 0; mT = 0; mSteps = 0; mPhase = 2; mTag = "R7"; end
        2: begin
          modelStep(); mSteps++; mTag = "R4";
          if (mSteps == 16) mPhase = 3;
        end
        3: begin
          bit hi;
          hi = mWork[31];
          mWork = {mWork[30:0], mT};
          mT = hi;
          mPhase = 4;
          mTag = "R9";
        end
        default: begin mPhase = 0; mTag = "R5"; end
      endcase
    end
  end

  task automatic check(string tag, string what, longint unsigned act, longint unsigned exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chkEn) begin
      check(mTag, "workO", workO, mWork);
      check(mTag, "tFlagO", tFlagO, mT);
      check(mTag, "qFlagO", qFlagO, mQ);
      check((mPhase != 0) ? "R5" : mTag, "busyO", busyO, mPhase != 0);
      check("R5", "doneO", doneO, mPhase == 4);
    end
  end

  always @(posedge clk) begin
    if (cycCnt > 150000) begin
      failCnt++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  task automatic runDiv(logic [31:0] a, logic [15:0] b);
    bit seen;
    @(negedge clk);
    dividendI = a; divisorI = b; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (doneO) begin
        seen = 1;
        // R6: quotient from integer division
        check("R6", "quotientO", quotientO, {16'h0, 16'(a / {16'h0, b})});
      end
    end
    check("R5", "doneO seen", seen, 1);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busyO", busyO, 0);
    check("R1", "doneO", doneO, 0);
    check("R1", "workO", workO, 0);
    check("R1", "tFlagO", tFlagO, 0);
    check("R1", "qFlagO", qFlagO, 0);
    rstN = 1'b1;
    chkEn = 1'b1;
    repeat (3) @(negedge clk);

    runDiv(32'd100, 16'd7);
    runDiv(32'h0000FFFF, 16'd1);
    runDiv(32'h12345678, 16'hFFFF);
    runDiv(32'h0, 16'd5);
    runDiv(32'h7FFFFFFF, 16'h8000);
    runDiv(32'h0006ABCD, 16'd7);
    runDiv(32'h00AA5555, 16'h00AB);

    // R7: commands during a run are ignored
    @(negedge clk);
    dividendI = 32'h00001000; divisorI = 16'd3; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    repeat (4) @(negedge clk);
    dividendI = 32'h0000FFFF; divisorI = 16'd1;
    startI = 1'b1; loadI = 1'b1; initI = 1'b1; stepI = 1'b1;
    @(negedge clk);
    startI = 1'b0; loadI = 1'b0; initI = 1'b0; stepI = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (doneO) check("R7", "quotient unchanged by busy commands", quotientO, 32'h1000 / 3);
    end

    // Manual path: load, a few steps, then prepare and step together (R8)
    dividendI = 32'h0003F00F; divisorI = 16'h0005; loadI = 1'b1;
    @(negedge clk);
    loadI = 1'b0;
    check("R2", "workO after load", workO, 32'h0003F00F);
    stepI = 1'b1;
    repeat (3) @(negedge clk);
    stepI = 1'b0;
    repeat (2) @(negedge clk);
    initI = 1'b1; stepI = 1'b1;
    @(negedge clk);
    initI = 1'b0; stepI = 1'b0;
    check("R3", "tFlagO after prepare", tFlagO, 0);
    check("R3", "qFlagO after prepare", qFlagO, 0);

    // R8: start wins over load
    dividendI = 32'h00000063; divisorI = 16'd9; startI = 1'b1; loadI = 1'b1;
    @(negedge clk);
    startI = 1'b0; loadI = 1'b0;
    check("R8", "busyO after start+load", busyO, 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (doneO) check("R8", "quotient start+load", quotientO, 11);
    end

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule